// File: doc/BRIEF.md
# Class-Aware Flit Packet Framer

This block sits behind one input port of a network router and splits an incoming stream of 39-bit flits into packets. Each flit holds a 32-bit data word and 7 check bits. The framer does not examine the check bits; it forwards them unchanged. Packets have no fixed length. The first flit of a packet is the header. The header names one of seven packet classes, and for some classes it also picks one of two lengths. The framer decodes that header, loads a down-counter with the remaining flit count, and then tags every flit it forwards. Each forwarded flit carries its class, a header flag, a last flag and its index within the packet.

Flits enter and leave through valid/ready handshakes. A single output register stage means an accepted flit is presented one cycle later. Downstream backpressure stalls the framer without losing or repeating flits. A header that carries the unused class code is consumed and not forwarded, and it raises a one-cycle error strobe. The flit after it is then treated as a new header. Routing, buffering and error correction belong to other blocks.

Top module: `flit_framer`

## Requirements
- R1: After a synchronous reset, out_valid and err_bad_class are low and in_ready is high.
- R2: Header fields: flit bits [31:29] hold the class code and bit [28] holds the length variant. Bits [38:32] are the check bits. Bits [27:0] of a header and all bits of later flits are not decoded.
- R3: Fixed-length classes ignore the variant bit. Class 0 (request) is 3 flits. Class 1 (forward) is 3 flits. Class 4 (write I/O) is 19 flits. Class 5 (read I/O) is 3 flits.
- R4: Variable-length classes use the variant bit (0 gives the first length, 1 the second). Class 2 (block response) is 18 or 19 flits. Class 3 (non-block response) is 2 or 3 flits. Class 6 (special) is 1 or 3 flits.
- R5: The first flit of a packet is output with out_head=1 and out_index=0. Each later flit has out_head=0, and its index is one more than that of the flit before it.
- R6: out_last is 1 only on the final flit of a packet. A 1-flit packet shows out_head and out_last together.
- R7: out_class carries the header's class code on every flit of the packet, whatever the payload bits contain.
- R8: A header with class code 7 is accepted but not forwarded. err_bad_class is high for exactly the following cycle, and the next accepted flit is decoded as a header.
- R9: out_flit equals the accepted input flit in all 39 bits, check bits included.
- R10: While out_valid=1 and out_ready=0, in_ready is 0 and all outputs hold steady. No flit is lost or duplicated across a stall.
- R11: A flit accepted on one clock edge appears on the outputs right after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Framer can take a flit |
| in_flit | input | 39 | Input flit: check bits [38:32], data [31:0] |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream can take a flit |
| out_flit | output | 39 | Forwarded flit |
| out_class | output | 3 | Class code of the packet |
| out_head | output | 1 | Flit is a packet header |
| out_last | output | 1 | Flit ends its packet |
| out_index | output | 5 | Position of the flit within its packet |
| err_bad_class | output | 1 | One-cycle strobe: a header with class code 7 was dropped |

## Verification
The assertions assume that the downstream side may drop out_ready at any time. They also assume that the upstream side presents a flit stream whose headers fall where the counted lengths put them. Under that assumption, every packet on the output starts with a header and is followed by the number of payload flits its class implies. The stimulus builds each packet from a table of class, variant and expected length. It sends exactly that many flits and never inserts a stray flit mid-packet. Backpressure is applied only through out_ready, so the stream itself always stays well framed.

// File: rtl/flit_pkg.sv
package flit_pkg;
  localparam int FLIT_W  = 39;
  localparam int DATA_W  = 32;
  localparam int CLS_W   = 3;
  localparam int MAX_LEN = 19;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int CLS_LSB = DATA_W - CLS_W;   // class field top of data word
  localparam int VAR_BIT = CLS_LSB - 1;      // variant selector just below it

  typedef enum logic [CLS_W-1:0] {
    CLS_REQ     = 3'd0,
    CLS_FWD     = 3'd1,
    CLS_BLK_RSP = 3'd2,
    CLS_NB_RSP  = 3'd3,
    CLS_WR_IO   = 3'd4,
    CLS_RD_IO   = 3'd5,
    CLS_SPECIAL = 3'd6,
    CLS_BAD     = 3'd7
  } pkt_class_e;

  // Packet length for a class/variant pair; 0 marks an illegal code.
  function automatic logic [LEN_W-1:0] pkt_len(input pkt_class_e c, input logic v);
    case (c)
      CLS_REQ, CLS_FWD, CLS_RD_IO: pkt_len = LEN_W'(3);
      CLS_WR_IO:                   pkt_len = LEN_W'(19);
      CLS_BLK_RSP:                 pkt_len = v ? LEN_W'(19) : LEN_W'(18);
      CLS_NB_RSP:                  pkt_len = v ? LEN_W'(3)  : LEN_W'(2);
      CLS_SPECIAL:                 pkt_len = v ? LEN_W'(3)  : LEN_W'(1);
      default:                     pkt_len = '0;
    endcase
  endfunction
endpackage

// File: rtl/flit_class_decode.sv
module flit_class_decode
  import flit_pkg::*;
#(
  parameter int W = FLIT_W
) (
  input  logic [W-1:0]     flit,
  output pkt_class_e       cls,
  output logic [LEN_W-1:0] len,
  output logic             legal
);
  logic var_sel;

  always_comb begin
    cls     = pkt_class_e'(flit[CLS_LSB +: CLS_W]);
    var_sel = flit[VAR_BIT];
    len     = pkt_len(cls, var_sel);
    legal   = (len != '0);
  end
endmodule

// File: rtl/flit_frame_ctrl.sv
module flit_frame_ctrl
  import flit_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  pkt_class_e       hdr_cls,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic             hdr_legal,
  output logic             fwd,
  output logic             bad,
  output logic             head,
  output logic             last,
  output logic [LEN_W-1:0] index,
  output pkt_class_e       cls
);
  logic             busy_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] idx_q;
  pkt_class_e       cls_q;

  // Tags for the flit currently offered at the input.
  always_comb begin
    if (!busy_q) begin
      head  = 1'b1;
      index = '0;
      cls   = hdr_cls;
      last  = (hdr_len == LEN_W'(1));
      fwd   = hdr_legal;
      bad   = !hdr_legal;
    end else begin
      head  = 1'b0;
      index = idx_q + LEN_W'(1);
      cls   = cls_q;
      last  = (rem_q == LEN_W'(1));
      fwd   = 1'b1;
      bad   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      idx_q  <= '0;
      cls_q  <= CLS_REQ;
    end else if (accept) begin
      if (!busy_q) begin
        if (hdr_legal) begin
          rem_q  <= hdr_len - LEN_W'(1);
          busy_q <= (hdr_len != LEN_W'(1));
          idx_q  <= '0;
          cls_q  <= hdr_cls;
        end
      end else begin
        rem_q  <= rem_q - LEN_W'(1);
        busy_q <= (rem_q != LEN_W'(1));
        idx_q  <= index;
      end
    end
  end
endmodule

// File: rtl/flit_out_stage.sv
module flit_out_stage
  import flit_pkg::*;
#(
  parameter int W = FLIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             accept,
  input  logic [W-1:0]     nxt_flit,
  input  logic             nxt_fwd,
  input  logic             nxt_bad,
  input  logic             nxt_head,
  input  logic             nxt_last,
  input  logic [LEN_W-1:0] nxt_index,
  input  pkt_class_e       nxt_cls,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_flit,
  output pkt_class_e       out_cls,
  output logic             out_head,
  output logic             out_last,
  output logic [LEN_W-1:0] out_index,
  output logic             err
);
  always_comb begin
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      out_flit  <= '0;
      out_cls   <= CLS_REQ;
      out_head  <= 1'b0;
      out_last  <= 1'b0;
      out_index <= '0;
    end else begin
      err <= accept && nxt_bad;
      if (accept && nxt_fwd) begin
        out_valid <= 1'b1;
        out_flit  <= nxt_flit;
        out_cls   <= nxt_cls;
        out_head  <= nxt_head;
        out_last  <= nxt_last;
        out_index <= nxt_index;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flit_framer.sv
module flit_framer
  import flit_pkg::*;
#(
  parameter int W = FLIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_flit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_flit,
  output logic [CLS_W-1:0] out_class,
  output logic             out_head,
  output logic             out_last,
  output logic [LEN_W-1:0] out_index,
  output logic             err_bad_class
);
  pkt_class_e       dec_cls, nxt_cls, reg_cls;
  logic [LEN_W-1:0] dec_len, nxt_index;
  logic             dec_legal, accept;
  logic             nxt_fwd, nxt_bad, nxt_head, nxt_last;

  flit_class_decode #(.W(W)) dec_i (
    .flit(in_flit), .cls(dec_cls), .len(dec_len), .legal(dec_legal)
  );

  flit_frame_ctrl ctrl_i (
    .clk(clk), .rst(rst), .accept(accept),
    .hdr_cls(dec_cls), .hdr_len(dec_len), .hdr_legal(dec_legal),
    .fwd(nxt_fwd), .bad(nxt_bad), .head(nxt_head), .last(nxt_last),
    .index(nxt_index), .cls(nxt_cls)
  );

  flit_out_stage #(.W(W)) ostg_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .nxt_flit(in_flit), .nxt_fwd(nxt_fwd), .nxt_bad(nxt_bad),
    .nxt_head(nxt_head), .nxt_last(nxt_last), .nxt_index(nxt_index),
    .nxt_cls(nxt_cls), .out_valid(out_valid), .out_ready(out_ready),
    .out_flit(out_flit), .out_cls(reg_cls), .out_head(out_head),
    .out_last(out_last), .out_index(out_index), .err(err_bad_class)
  );

  assign out_class = reg_cls;
endmodule

// File: rtl/flit_framer_chk.sv
module flit_framer_chk
  import flit_pkg::*;
#(
  parameter int W = FLIT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_flit,
  input logic [CLS_W-1:0] out_class,
  input logic             out_head,
  input logic             out_last,
  input logic [LEN_W-1:0] out_index
);
  logic expect_head;

  always_ff @(posedge clk) begin
    if (rst) expect_head <= 1'b1;
    else if (out_valid && out_ready) expect_head <= out_last;
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_flit) &&
      $stable(out_index) && $stable(out_last) && $stable(out_head));

  p_stall_no_take_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_head_index_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_head |-> out_index == '0);

  p_head_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && expect_head |-> out_head);

  p_legal_class_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_class != CLS_W'(7));

  p_req_len_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && out_class == CLS_W'(0) |-> out_index == LEN_W'(2));

  p_max_len_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_index < LEN_W'(MAX_LEN));
endmodule

bind flit_framer flit_framer_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
  .out_class(out_class), .out_head(out_head), .out_last(out_last),
  .out_index(out_index)
);

// File: tb/flit_framer_tb_top.sv
`timescale 1ns/1ps
module flit_framer_tb_top;
  localparam int W = 39;
  localparam int NV = 10;
  // {class[2:0], variant, expected length[4:0]}
  localparam logic [8:0] VEC [NV] = '{
    {3'd0, 1'b1, 5'd3},  {3'd1, 1'b0, 5'd3},  {3'd2, 1'b0, 5'd18},
    {3'd2, 1'b1, 5'd19}, {3'd3, 1'b0, 5'd2},  {3'd3, 1'b1, 5'd3},
    {3'd4, 1'b1, 5'd19}, {3'd5, 1'b0, 5'd3},  {3'd6, 1'b0, 5'd1},
    {3'd6, 1'b1, 5'd3}
  };

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 1;
  logic [W-1:0] in_flit = '0;
  logic in_ready, out_valid, out_head, out_last, err_bad_class;
  logic [W-1:0] out_flit;
  logic [2:0] out_class;
  logic [4:0] out_index;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  flit_framer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
    .out_flit(out_flit), .out_class(out_class), .out_head(out_head),
    .out_last(out_last), .out_index(out_index), .err_bad_class(err_bad_class)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] hdr(input logic [2:0] c, input logic v, input logic [6:0] ecc);
    return {ecc, c, v, 28'h5A5_1234};
  endfunction

  // Drive one flit, then check the tagged output one cycle later (R11).
  task automatic send(input logic [W-1:0] f, input bit h, input bit l,
                      input int idx, input logic [2:0] c, input string req);
    @(negedge clk);
    in_valid = 1; in_flit = f;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 1, {req, " R11 valid"}, out_valid, 1);
    chk(out_flit == f, {req, " R9 flit"}, out_flit, f);
    chk(out_head == h, {req, " R5 head"}, out_head, h);
    chk(out_last == l, {req, " R6 last"}, out_last, l);
    chk(out_index == 5'(idx), {req, " R5 index"}, out_index, idx);
    chk(out_class == c, {req, " R7 class"}, out_class, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(err_bad_class == 0, "R1 err", err_bad_class, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);

    // Table walk: R2 R3 R4 lengths per class/variant.
    for (int i = 0; i < NV; i++) begin
      logic [2:0] c;
      logic v;
      int n;
      c = VEC[i][8:6]; v = VEC[i][5]; n = int'(VEC[i][4:0]);
      send(hdr(c, v, 7'(i + 3)), 1, n == 1, 0, c, "R2 hdr");
      for (int k = 1; k < n; k++)
        send({7'(k), 32'hE000_0000 | 32'(k)}, 0, k == n - 1, k, c,
             (c == 3'd2 || c == 3'd3 || c == 3'd6) ? "R4 body" : "R3 body");
    end

    // R8: bad class dropped, next flit is a header.
    @(negedge clk);
    in_valid = 1; in_flit = hdr(3'd7, 1'b0, 7'h11);
    @(negedge clk);
    in_valid = 0;
    chk(err_bad_class == 1, "R8 err strobe", err_bad_class, 1);
    chk(out_valid == 0, "R8 not forwarded", out_valid, 0);
    @(negedge clk);
    chk(err_bad_class == 0, "R8 err one cycle", err_bad_class, 0);
    send(hdr(3'd6, 1'b0, 7'h22), 1, 1, 0, 3'd6, "R8 resync R6 single");

    // R10: stall with out_ready low.
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_flit = hdr(3'd0, 1'b0, 7'h33);
    @(negedge clk);
    in_flit = {7'h01, 32'h0000_0001};
    chk(out_valid == 1 && out_head == 1, "R10 header held", out_head, 1);
    chk(in_ready == 0, "R10 in_ready low", in_ready, 0);
    @(negedge clk);
    chk(out_flit == hdr(3'd0, 1'b0, 7'h33), "R10 stable", out_flit, hdr(3'd0, 1'b0, 7'h33));
    chk(out_index == 0, "R10 no advance", out_index, 0);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_index == 1 && out_flit == {7'h01, 32'h0000_0001}, "R10 next flit", out_index, 1);
    send({7'h02, 32'h2}, 0, 1, 2, 3'd0, "R10 tail R6");
    @(negedge clk);
    chk(out_valid == 0, "R10 no duplicate", out_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule